// File: doc/BRIEF.md
# Addressed Serial Code Register Bank

This block is the receive side of a three-wire serial write port. A host frames each write with an active-low frame-sync, shifts bits on the falling edge of a serial clock, and the block routes a 14-bit code into one of 32 output-code registers. The register values leave the block on a flat bus and feed downstream converters. They keep their value until the next write or reset.

All three serial inputs and the broadcast input are oversampled in a faster system clock through two-flop synchronizers, and edges are detected there. A frame-sync falling edge arms a bit counter. After the last bit of the frame, the counter ignores the serial clock and any further frame-sync edges until it is armed again. When the broadcast input is high, a completed frame writes every register at once. Each completed write raises a one-cycle strobe that carries the channel index and a broadcast flag.

Top module: `serial_code_bank`

## Requirements
- R1: A frame has 19 bits and is sent most significant bit first. The first five bits are the channel address, bit 4 down to bit 0. The last fourteen bits are the code, bit 13 down to bit 0. A bit is taken on each falling serial-clock edge seen while frame-sync is low and the counter is armed.
- R2: Only a frame-sync falling edge arms the counter, and arming clears the count. Serial-clock edges taken while the counter is not armed, including those after reset while frame-sync is held low, write nothing.
- R3: Once the counter is armed, a frame-sync rising or falling edge neither restarts nor aborts the count. Edges that arrive while frame-sync is high are not taken. The frame completes when its 19th bit arrives, even if it spans several frame-sync low windows.
- R4: After the 19th bit, further serial-clock edges change no register and raise no strobe until a new frame-sync falling edge arrives.
- R5: When the broadcast input is low, a completed frame writes its code into the single register selected by the address, and leaves every other register unchanged. All addresses 0 to 31 are valid.
- R6: When the broadcast input is high, a completed frame writes its code into all 32 registers, whatever the address.
- R7: While the asynchronous active-low reset is low, all registers, the strobe, the index and the broadcast flag read zero, and any partial frame is discarded.
- R8: Each completed frame raises `upd_o` for exactly one system-clock cycle. In that cycle `upd_ch_o` holds the frame's address and `upd_all_o` holds the broadcast state. The registers show the new code in the same cycle.
- R9: A serial clock that runs freely between frames gives the same results as one that is gated to the frame.
- R10: Writes are correct when the system clock runs 4 or more times faster than the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_n | input | 1 | Active-low frame sync |
| sck | input | 1 | Serial clock; data taken on its falling edge |
| sdi | input | 1 | Serial data, most significant bit first |
| bcast | input | 1 | High: a completed frame writes all registers |
| codes_o | output | 448 | Register values; channel n sits at bits 14n+13 down to 14n |
| upd_o | output | 1 | One-cycle strobe for each completed write |
| upd_ch_o | output | 5 | Address of the completed write |
| upd_all_o | output | 1 | The completed write was a broadcast |

## Verification
A wrong bit count or shift order puts a wrong code, or the right code in the wrong channel, on `codes_o`. This is visible as soon as the 19th bit has passed through the synchronizers, about four system cycles after its serial edge. A counter that is not correctly disarmed shows up as an extra strobe, or as a corrupted register after the trailing edges of the next frame. A broadcast or address decode fault leaves the wrong set of channels changed in the same cycle as the strobe. The sweep therefore compares all 32 registers and the strobe count after every frame.

// File: rtl/serial_code_bank.sv
`timescale 1ns/1ps
module serial_code_bank #(
  parameter int NCH = 32,
  parameter int AW  = 5,
  parameter int DW  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              bcast,
  output logic [NCH*DW-1:0] codes_o,
  output logic              upd_o,
  output logic [AW-1:0]     upd_ch_o,
  output logic              upd_all_o
);
  localparam int FB = AW + DW;
  localparam int CW = $clog2(FB + 1);

  logic [1:0]    frm_sy, sck_sy, sdi_sy, tst_sy;
  logic          frm_d, sck_d;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [FB-2:0] shreg;
  logic [DW-1:0] bank [NCH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frm_sy <= '0; sck_sy <= '0; sdi_sy <= '0; tst_sy <= '0;
      frm_d  <= 1'b0; sck_d <= 1'b0;
    end else begin
      frm_sy <= {frm_sy[0], frm_n};
      sck_sy <= {sck_sy[0], sck};
      sdi_sy <= {sdi_sy[0], sdi};
      tst_sy <= {tst_sy[0], bcast};
      frm_d  <= frm_sy[1];
      sck_d  <= sck_sy[1];
    end

  wire          frm_fall = frm_d & ~frm_sy[1];
  wire          sck_fall = sck_d & ~sck_sy[1];
  wire          bit_ok   = armed & sck_fall & ~frm_sy[1];
  wire          last_bit = bit_ok && (cnt == CW'(FB - 1));
  wire [FB-1:0] word     = {shreg, sdi_sy[1]};
  wire [AW-1:0] wr_addr  = word[FB-1 -: AW];
  wire [DW-1:0] wr_data  = word[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0; cnt <= '0; shreg <= '0;
      upd_o <= 1'b0; upd_ch_o <= '0; upd_all_o <= 1'b0;
    end else begin
      if (!armed && frm_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (bit_ok) begin
        shreg <= word[FB-2:0];
        cnt   <= cnt + 1'b1;
        if (last_bit) armed <= 1'b0;
      end
      upd_o <= last_bit;
      if (last_bit) begin
        upd_ch_o  <= wr_addr;
        upd_all_o <= tst_sy[1];
      end
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bank[i] <= '0;
      else if (last_bit && (tst_sy[1] || wr_addr == AW'(i))) bank[i] <= wr_data;
    assign codes_o[i*DW +: DW] = bank[i];

    a_r5_only_target_changes: assert property (@(posedge clk) disable iff (!rst_n)
      (bank[i] != $past(bank[i])) |-> (upd_o && (upd_all_o || upd_ch_o == AW'(i))));
    a_r6_broadcast_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && upd_all_o) |-> (bank[i] == bank[0]));
  end

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);
  a_r4_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !frm_fall) |=> ($stable(cnt) && $stable(shreg) && !upd_o));
  a_r3_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sck_fall) |=> (armed && $stable(cnt)));
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FB));
endmodule

// File: tb/test_serial_code_bank.sv
`timescale 1ns/1ps
module test_serial_code_bank;
  localparam int NCH = 32, AW = 5, DW = 14;
  logic clk = 1'b0, rst_n = 1'b0, frm_n = 1'b1, sck = 1'b1, sdi = 1'b0, bcast = 1'b0;
  logic [NCH*DW-1:0] codes_o;
  logic upd_o, upd_all_o;
  logic [AW-1:0] upd_ch_o;

  serial_code_bank i_serial_code_bank (.clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sck(sck),
    .sdi(sdi), .bcast(bcast), .codes_o(codes_o), .upd_o(upd_o), .upd_ch_o(upd_ch_o),
    .upd_all_o(upd_all_o));

  always #5 clk = ~clk;

  int total = 0, bad = 0, n_upd = 0, n_exp = 0;
  int last_ch = 0, last_all = 0;
  logic [DW-1:0] model [NCH];

  always @(negedge clk) if (upd_o) begin
    n_upd++; last_ch = upd_ch_o; last_all = upd_all_o;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_bank(string tag);
    for (int c = 0; c < NCH; c++) chk(tag, codes_o[c*DW +: DW], model[c]);
    chk({tag, " strobe count"}, n_upd, n_exp);
  endtask

  task automatic sbit(bit b, int h);
    sdi = b; #(h) sck = 1'b0; #(h) sck = 1'b1;
  endtask

  task automatic send(int a, int d, int h, bit cont);
    logic [AW+DW-1:0] w = {AW'(a), DW'(d)};
    frm_n = 1'b0; #(h);
    for (int i = AW+DW-1; i >= 0; i--) sbit(w[i], h);
    #(h) frm_n = 1'b1;
    if (cont) repeat (4) sbit(1'b1, h); else #(8*h);
    #100;
  endtask

  task automatic expect_write(int a, int d, bit all);
    if (all) for (int c = 0; c < NCH; c++) model[c] = DW'(d);
    else model[a] = DW'(d);
    n_exp++;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    #55;
    chk("R7 reset strobe", upd_o, 0);
    rst_n = 1'b1; #100;
    chk_bank("R7 reset state");

    // R1 R5: gated clock sweep of every address, 8x oversampling
    for (int a = 0; a < NCH; a++) begin
      int d = (a * 1237 + 341) & 16'h3fff;
      send(a, d, 40, 1'b0);
      expect_write(a, d, 1'b0);
      chk_bank("R5 addressed write");
      chk("R8 strobe channel", last_ch, a);
      chk("R8 strobe broadcast flag", last_all, 0);
    end
    send(31, 16'h3fff, 40, 1'b0); expect_write(31, 16'h3fff, 1'b0); chk_bank("R1 all-ones code");
    send(0, 0, 40, 1'b0);         expect_write(0, 0, 1'b0);         chk_bank("R1 zero code");

    // R9 R10: free-running clock at 4x oversampling
    for (int a = NCH-1; a >= 0; a--) begin
      int d = (a * 2999 + 77) & 16'h3fff;
      send(a, d, 20, 1'b1);
      expect_write(a, d, 1'b0);
      chk_bank("R9 R10 continuous clock write");
    end

    // R6: broadcast ignores the address
    bcast = 1'b1; #100;
    send(13, 16'h2a5c, 40, 1'b0);
    expect_write(13, 16'h2a5c, 1'b1);
    chk_bank("R6 broadcast");
    chk("R6 strobe broadcast flag", last_all, 1);
    bcast = 1'b0; #100;

    // R3: frame split across two sync-low windows, with edges while high
    begin
      logic [AW+DW-1:0] w = {5'd9, 14'h1b3d};
      frm_n = 1'b0; #40;
      for (int i = 18; i >= 9; i--) sbit(w[i], 40);
      #40 frm_n = 1'b1; #40;
      sbit(~w[8], 40); sbit(~w[8], 40);
      frm_n = 1'b0; #40;
      for (int i = 8; i >= 0; i--) sbit(w[i], 40);
      #40 frm_n = 1'b1; #400;
      expect_write(9, 16'h1b3d, 1'b0);
      chk_bank("R3 split frame");
      chk("R3 channel", last_ch, 9);
    end

    // R4: trailing edges after the 19th bit
    begin
      logic [AW+DW-1:0] w = {5'd22, 14'h0f0f};
      frm_n = 1'b0; #40;
      for (int i = 18; i >= 0; i--) sbit(w[i], 40);
      for (int k = 0; k < 6; k++) sbit(k[0], 40);
      #40 frm_n = 1'b1; #400;
      expect_write(22, 16'h0f0f, 1'b0);
      chk_bank("R4 trailing edges ignored");
    end

    // R7 R2: reset mid-frame while sync held low, then unarmed edges
    frm_n = 1'b0; #40;
    for (int i = 0; i < 7; i++) sbit(1'b1, 40);
    rst_n = 1'b0; #30;
    for (int c = 0; c < NCH; c++) model[c] = '0;
    for (int c = 0; c < NCH; c++) chk("R7 registers in reset", codes_o[c*DW +: DW], 0);
    chk("R7 channel in reset", upd_ch_o, 0);
    rst_n = 1'b1; #100;
    for (int i = 0; i < 19; i++) sbit(1'b1, 40);
    #40 frm_n = 1'b1; #400;
    chk_bank("R2 unarmed edges ignored");
    send(5, 16'h1234, 40, 1'b0);
    expect_write(5, 16'h1234, 1'b0);
    chk_bank("R2 rearm after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule